// File: doc/BRIEF.md
# Tiled Surface Footprint Checker

This block decides whether a block-linear tiled surface fits inside the memory region that backs it. A request carries the row pitch in bytes, the height in pixel rows, a tile-mode word, a starting byte offset, the size of the backing region, a chip revision code and a flag marking the oldest chip family. The block pulls the block-height exponent out of the tile-mode word. Which bits hold that exponent depends on the revision code. Any stray bit in the word makes the request illegal.

For a legal mode, the block rounds the pitch up to whole 64-byte columns. It rounds the height up to whole blocks, where one block is a stack of 2^exponent byte groups and each byte group is 4 or 8 rows tall. From the two block counts it forms the tiled footprint in bytes. It then tests footprint plus offset against the region size.

Requests enter through a valid/ready handshake. The work is spread over a short fixed sequence of cycles. The status code and the computed footprint are held on the output until the consumer takes them.

Top module: `tile_fit_check`

## Requirements
- R1: While rst_n is low and on the first cycle after its release, in_ready is 1 and out_valid is 0.
- R2: A request is taken on a clock edge where in_valid and in_ready are both 1. in_ready stays 0 from that edge until the result is consumed. out_valid rises exactly three clock edges after the accepting edge.
- R3: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_status and out_footprint do not change. The edge where both out_valid and out_ready are 1 consumes the result, and out_valid is 0 after it.
- R4: The width in blocks is the row pitch divided by 64, rounded up.
- R5: A byte group is 4 rows (256 bytes) when in_old_family is 1, and 8 rows (512 bytes) when it is 0.
- R6: When in_rev is 0xC0 or above, the exponent is in_mode[7:4]. Any set bit of in_mode outside bits 7..4 gives status 01.
- R7: When in_rev is below 0xC0, the exponent is in_mode[3:0]. Any set bit of in_mode above bit 3 gives status 01.
- R8: The height in blocks is the pixel height divided by (group rows × 2^exponent), rounded up. The footprint is width_in_blocks × height_in_blocks × 2^exponent × group bytes.
- R9: For a legal mode, the status is 10 when footprint + offset is greater than in_size, and 00 when it is equal or smaller. out_footprint carries the footprint in both cases.
- R10: Status codes are 00 for fits, 01 for illegal tile mode and 10 for out of range; 11 is never produced. With status 01, out_footprint is 0.
- R11: in_ready and out_valid are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to take a request |
| in_stride | input | 32 | Row pitch in bytes |
| in_height | input | 32 | Surface height in pixel rows |
| in_mode | input | 32 | Tile-mode word |
| in_offset | input | 64 | Byte offset of the surface in the region |
| in_size | input | 64 | Size of the backing region in bytes |
| in_rev | input | 16 | Chip revision code |
| in_old_family | input | 1 | 1 selects 4-row byte groups |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_status | output | 2 | 00 fits, 01 illegal mode, 10 out of range |
| out_footprint | output | 64 | Tiled footprint in bytes |

## Verification
On every cycle the assertions check the handshake rules: a result held steady during a stall, in_ready and out_valid never both high, in_ready dropping after acceptance, and valid dropping after consumption. They also check that code 11 never appears and that an illegal mode reports a zero footprint. The arithmetic can only be shown by the bench's scenarios, because no property can judge it without recomputing it. These scenarios cover the rounding of pitch and height, the family row height, the revision threshold at 0xC0 against 0xBF for the mode field, and the exact-fit boundary against a one-byte overrun. The bench's cycle model confirms the exact three-edge latency.

// File: rtl/tile_fit_pkg.sv
package tile_fit_pkg;

  typedef enum logic [1:0] {
    FIT_OK       = 2'b00,
    FIT_BAD_MODE = 2'b01,
    FIT_RANGE    = 2'b10
  } fit_status_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_DIMS = 3'd1,
    PH_MULT = 3'd2,
    PH_CMP  = 3'd3,
    PH_RESP = 3'd4
  } fit_phase_e;

  localparam int unsigned COL_BYTES_LOG = 6;

endpackage

// File: rtl/tile_mode_decode.sv
module tile_mode_decode #(
  parameter int unsigned MODE_W  = 32,
  parameter int unsigned REV_W   = 16,
  parameter int unsigned NEW_REV = 'hC0
) (
  input  logic [MODE_W-1:0] mode_word,
  input  logic [REV_W-1:0]  rev_code,
  output logic [3:0]        exp_log,
  output logic              mode_bad
);
  localparam logic [MODE_W-1:0] HI_FIELD = MODE_W'('hF0);
  localparam logic [MODE_W-1:0] LO_FIELD = MODE_W'('h0F);

  logic use_hi;
  assign use_hi = (rev_code >= REV_W'(NEW_REV));

  always_comb begin
    if (use_hi) begin
      exp_log  = mode_word[7:4];
      mode_bad = |(mode_word & ~HI_FIELD);
    end else begin
      exp_log  = mode_word[3:0];
      mode_bad = |(mode_word & ~LO_FIELD);
    end
  end
endmodule

// File: rtl/tile_grid_calc.sv
module tile_grid_calc
  import tile_fit_pkg::*;
#(
  parameter int unsigned STRIDE_W = 32,
  parameter int unsigned HEIGHT_W = 32,
  parameter int unsigned FOOT_W   = 64
) (
  input  logic [STRIDE_W-1:0] pitch,
  input  logic [HEIGHT_W-1:0] rows,
  input  logic [3:0]          exp_log,
  input  logic                old_family,
  output logic [FOOT_W-1:0]   cols_blk,
  output logic [FOOT_W-1:0]   rows_blk,
  output logic [4:0]          byte_shift
);
  localparam logic [FOOT_W-1:0] COL_ROUND = FOOT_W'((1 << COL_BYTES_LOG) - 1);

  logic [4:0]        blk_rows_log;
  logic [FOOT_W-1:0] row_round;

  assign blk_rows_log = 5'(exp_log) + (old_family ? 5'd2 : 5'd3);
  assign row_round    = (FOOT_W'(1) << blk_rows_log) - FOOT_W'(1);

  assign cols_blk   = (FOOT_W'(pitch) + COL_ROUND) >> COL_BYTES_LOG;
  assign rows_blk   = (FOOT_W'(rows) + row_round) >> blk_rows_log;
  assign byte_shift = blk_rows_log + 5'(COL_BYTES_LOG);
endmodule

// File: rtl/tile_fit_check.sv
module tile_fit_check
  import tile_fit_pkg::*;
#(
  parameter int unsigned STRIDE_W = 32,
  parameter int unsigned HEIGHT_W = 32,
  parameter int unsigned MODE_W   = 32,
  parameter int unsigned FOOT_W   = 64,
  parameter int unsigned REV_W    = 16,
  parameter int unsigned NEW_REV  = 'hC0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [STRIDE_W-1:0] in_stride,
  input  logic [HEIGHT_W-1:0] in_height,
  input  logic [MODE_W-1:0]   in_mode,
  input  logic [FOOT_W-1:0]   in_offset,
  input  logic [FOOT_W-1:0]   in_size,
  input  logic [REV_W-1:0]    in_rev,
  input  logic                in_old_family,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [1:0]          out_status,
  output logic [FOOT_W-1:0]   out_footprint
);
  fit_phase_e phase_q, phase_d;

  // captured request
  logic [STRIDE_W-1:0] pitch_q;
  logic [HEIGHT_W-1:0] rows_q;
  logic [MODE_W-1:0]   mode_q;
  logic [FOOT_W-1:0]   offs_q, size_q;
  logic [REV_W-1:0]    rev_q;
  logic                oldf_q;

  // grid stage
  logic [FOOT_W-1:0] cols_d, rblk_d, cols_q, rblk_q;
  logic [4:0]        shift_d, shift_q;
  logic [3:0]        exp_d;
  logic              bad_d, bad_q, bad_m_q;

  // product and result stages
  logic [FOOT_W-1:0] foot_d, foot_q, res_foot_q;
  logic [FOOT_W:0]   end_addr;
  fit_status_e       res_stat_q, res_stat_d;

  logic take, give, en_req, en_dims, en_mult, en_cmp;

  assign take    = in_valid && (phase_q == PH_IDLE);
  assign give    = out_ready && (phase_q == PH_RESP);
  assign en_req  = take;
  assign en_dims = (phase_q == PH_DIMS);
  assign en_mult = (phase_q == PH_MULT);
  assign en_cmp  = (phase_q == PH_CMP);

  tile_mode_decode #(
    .MODE_W(MODE_W), .REV_W(REV_W), .NEW_REV(NEW_REV)
  ) u_decode (
    .mode_word(mode_q), .rev_code(rev_q), .exp_log(exp_d), .mode_bad(bad_d)
  );

  tile_grid_calc #(
    .STRIDE_W(STRIDE_W), .HEIGHT_W(HEIGHT_W), .FOOT_W(FOOT_W)
  ) u_grid (
    .pitch(pitch_q), .rows(rows_q), .exp_log(exp_d), .old_family(oldf_q),
    .cols_blk(cols_d), .rows_blk(rblk_d), .byte_shift(shift_d)
  );

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (take) phase_d = PH_DIMS;
      PH_DIMS: phase_d = PH_MULT;
      PH_MULT: phase_d = PH_CMP;
      PH_CMP:  phase_d = PH_RESP;
      PH_RESP: if (give) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  assign foot_d   = (cols_q * rblk_q) << shift_q;
  assign end_addr = {1'b0, foot_q} + {1'b0, offs_q};

  always_comb begin
    if (bad_m_q)                           res_stat_d = FIT_BAD_MODE;
    else if (end_addr > {1'b0, size_q})    res_stat_d = FIT_RANGE;
    else                                   res_stat_d = FIT_OK;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk) begin
    if (en_req) begin
      pitch_q <= in_stride;
      rows_q  <= in_height;
      mode_q  <= in_mode;
      offs_q  <= in_offset;
      size_q  <= in_size;
      rev_q   <= in_rev;
      oldf_q  <= in_old_family;
    end
    if (en_dims) begin
      cols_q  <= cols_d;
      rblk_q  <= rblk_d;
      shift_q <= shift_d;
      bad_q   <= bad_d;
    end
    if (en_mult) begin
      foot_q  <= bad_q ? '0 : foot_d;
      bad_m_q <= bad_q;
    end
    if (en_cmp) begin
      res_stat_q <= res_stat_d;
      res_foot_q <= foot_q;
    end
  end

  assign in_ready      = (phase_q == PH_IDLE);
  assign out_valid     = (phase_q == PH_RESP);
  assign out_status    = res_stat_q;
  assign out_footprint = res_foot_q;
endmodule

// File: rtl/tile_fit_check_sva.sv
module tile_fit_check_sva #(
  parameter int unsigned FOOT_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_status,
  input logic [FOOT_W-1:0] out_footprint
);
  assert_hold_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  assert_hold_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_status) && $stable(out_footprint)));

  assert_consume_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);

  assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_no_code11_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_status != 2'b11));

  assert_bad_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_status == 2'b01) |-> (out_footprint == '0));
endmodule

bind tile_fit_check tile_fit_check_sva #(.FOOT_W(FOOT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_status(out_status),
  .out_footprint(out_footprint)
);

// File: tb/tile_fit_check_test.sv
module tile_fit_check_test;
  logic        clk, rst_n;
  logic        in_valid, in_ready, out_valid, out_ready, in_old_family;
  logic [31:0] in_stride, in_height, in_mode;
  logic [63:0] in_offset, in_size, out_footprint;
  logic [15:0] in_rev;
  logic [1:0]  out_status;

  int total = 0;
  int fails = 0;
  int m_state = 0;
  bit done = 0;

  tile_fit_check uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_stride(in_stride), .in_height(in_height), .in_mode(in_mode),
    .in_offset(in_offset), .in_size(in_size), .in_rev(in_rev),
    .in_old_family(in_old_family), .out_valid(out_valid), .out_ready(out_ready),
    .out_status(out_status), .out_footprint(out_footprint)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint unsigned act,
                     input longint unsigned exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural cycle model: 0 idle, 1..3 working, 4 holding result
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_state <= 0;
    else case (m_state)
      0: if (in_valid) m_state <= 1;
      1, 2: m_state <= m_state + 1;
      3: m_state <= 4;
      default: if (out_ready) m_state <= 0;
    endcase
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(in_ready == (m_state == 0), "R2 in_ready", in_ready, m_state == 0);
      chk(out_valid == (m_state == 4), "R2 out_valid latency", out_valid, m_state == 4);
    end
  end

  function automatic void model(input longint unsigned s, h, m, off, sz, rev,
                                input bit oldf, output int st,
                                output longint unsigned fp);
    longint unsigned lg, rws, wb, hb;
    bit bad;
    if (rev >= 'hC0) begin bad = (m & 'hFFFFFF0F) != 0; lg = (m / 16) % 16; end
    else             begin bad = (m & 'hFFFFFFF0) != 0; lg = m % 16; end
    rws = oldf ? 4 : 8;
    wb  = (s + 63) / 64;
    hb  = (h + rws * (1 << lg) - 1) / (rws * (1 << lg));
    fp  = wb * hb * (1 << lg) * rws * 64;
    if (bad) begin st = 1; fp = 0; end
    else st = (fp + off > sz) ? 2 : 0;
  endfunction

  task automatic run(input longint unsigned s, h, m, off, sz, rev, input bit oldf,
                     input int stall, input string req);
    int st; longint unsigned fp; int guard = 0;
    model(s, h, m, off, sz, rev, oldf, st, fp);
    @(negedge clk);
    in_stride = 32'(s); in_height = 32'(h); in_mode = 32'(m);
    in_offset = off; in_size = sz; in_rev = 16'(rev); in_old_family = oldf;
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    while (!out_valid && guard < 20) begin @(negedge clk); guard++; end
    chk(out_status == 2'(st), {req, " status"}, out_status, st);
    chk(out_footprint == fp, {req, " footprint"}, out_footprint, fp);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(out_valid && out_status == 2'(st) && out_footprint == fp,
          "R3 hold during stall", out_footprint, fp);
    end
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk(!out_valid, "R3 consumed", out_valid, 0);
  endtask

  initial begin
    rst_n = 0; in_valid = 0; out_ready = 0; in_old_family = 0;
    in_stride = 0; in_height = 0; in_mode = 0; in_offset = 0; in_size = 0; in_rev = 0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1 && out_valid == 0, "R1 during reset", {in_ready, out_valid}, 2);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1 && out_valid == 0, "R1 after release", {in_ready, out_valid}, 2);

    // R8 R9: exact fit, one byte short, offset pushes past end
    run(4096, 1080, 'h40, 0, 4718592, 'hC0, 0, 0, "R9 exact fit");
    run(4096, 1080, 'h40, 0, 4718591, 'hC0, 0, 2, "R9 one byte short");
    run(4096, 1080, 'h40, 1, 4718592, 'hC0, 0, 0, "R9 offset overrun");
    // R6: new-revision field and stray bits
    run(4096, 1080, 'h41, 0, 64'hFFFF_FFFF, 'hC0, 0, 1, "R6 low bit stray");
    run(4096, 1080, 'h140, 0, 64'hFFFF_FFFF, 'hD0, 0, 0, "R6 high bit stray");
    // R7 vs R6: threshold at 0xC0
    run(256, 64, 'h10, 0, 64'hFFFF_FFFF, 'hBF, 0, 0, "R7 upper nibble illegal");
    run(256, 64, 'h10, 0, 64'hFFFF_FFFF, 'hC0, 0, 0, "R6 upper nibble legal");
    run(100, 33, 'h4, 0, 64'hFFFF_FFFF, 'h50, 1, 0, "R7 low nibble");
    // R5: same request under both families
    run(100, 33, 'h2, 0, 64'hFFFF_FFFF, 'h50, 1, 0, "R5 four-row group");
    run(100, 33, 'h2, 0, 64'hFFFF_FFFF, 'h50, 0, 0, "R5 eight-row group");
    // R4: pitch rounding
    run(64, 8, 'h0, 0, 64'hFFFF_FFFF, 'h50, 0, 0, "R4 pitch 64");
    run(65, 8, 'h0, 0, 64'hFFFF_FFFF, 'h50, 0, 1, "R4 pitch 65");
    run(1, 1, 'h0, 0, 512, 'h50, 0, 0, "R4 pitch 1");
    // R8: height rounding and zero height
    run(640, 129, 'h20, 0, 64'hFFFF_FFFF, 'hC8, 0, 0, "R8 height over block");
    run(640, 0, 'h20, 0, 0, 'hC8, 0, 0, "R8 zero height");
    // R10: illegal mode with tiny region still reports 01
    run(640, 480, 'hF000_0000, 0, 0, 'h20, 1, 3, "R10 illegal code");
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule